// File: doc/BRIEF.md
# I2C Register Slave with Chunked Wide-Register Writes

This block is an I2C target that gives a bus host access to a register space through a simple internal port. It runs on the system clock, not on SCL. SCL and SDA are oversampled, and the block answers on an open-drain SDA enable. After a write address, the first byte is a subaddress that loads an internal pointer. Byte registers then take any number of data bytes, and the pointer advances after each one. Reads are done with a repeated start, or with a current-address read, and return bytes from the same pointer.

Subaddresses in a second range select wide coefficient registers of 16 bytes each. Data written to a wide register is delivered byte by byte, with a byte offset. One long coefficient load can be split into 4-byte chunks that are sent as separate transactions. The first chunk names the register. Every later chunk is sent to the append subaddress 0xFE and resumes at the next offset. This holds even when other bus traffic, or a stop condition, falls between the chunks. The block never holds SCL low, so it runs at standard and fast bus rates with no wait states.

Top module: `i2c_append_regs`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0x36. Bit 0 selects the direction: 0 is a write and 1 is a read. With any other address it leaves SDA released for the address acknowledge and for every later byte, and it makes no write strobe until the next start condition.
- R2: In a write whose subaddress is 0x00 to 0x3F, each data byte makes one strobe with wr_addr equal to the pointer, wr_off equal to 0 and wr_data equal to the byte, and then the pointer advances. Bytes that fall at a pointer of 0x40 or above make no strobe. A write whose subaddress is 0x50 to 0xFD or 0xFF makes no strobe.
- R3: A read sends the byte for the current pointer on SDA, most significant bit first. The byte is rd_data when the pointer is 0x00 to 0x3F and 0x00 otherwise, which covers the wide range and 0xFE. The pointer advances by one per byte sent, up to 0x40. A master NACK ends the transfer with SDA released.
- R4: A write whose subaddress is 0x40 to 0x4F makes one strobe per data byte with wr_addr equal to that subaddress and wr_off counting 0, 1, 2 and so on. Bytes past offset 15 make no strobe.
- R5: A write to subaddress 0xFE continues the most recent wide-register write at the next offset, with the same wr_addr. This holds across stop conditions, across transactions to other addresses and across current-address reads.
- R6: Any subaddress byte other than 0xFE cancels the pending append. A later write to 0xFE then makes no strobe, although its bytes are still acknowledged.
- R7: A write to 0xFE made before any wide-register write since reset makes no strobe, and all of its bytes are acknowledged.
- R8: The block pulls SDA low only while SCL is low. It has no SCL output and never stretches the clock.
- R9: Each write strobe is high for exactly one system clock cycle.
- R10: After reset, sda_oe and wr_stb are low and no append is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 8 | Subaddress of the register written |
| wr_off | output | OFF_W (4) | Byte offset within a wide register, 0 for byte registers |
| wr_data | output | 8 | Byte written |
| rd_addr | output | 8 | Current pointer, for the read data lookup |
| rd_data | input | 8 | Byte register contents at rd_addr |

## Verification
A corrupted append pointer shows up on the strobe port in the first data byte of the next 0xFE chunk, as a wrong wr_offset or wr_addr or as a strobe that is missing or extra. Vectors that alternate byte writes, unmapped writes and appends expose each such error within one transaction. A wrong bit counter or wrong transmit state shows up as a missing acknowledge, or as a read byte shifted by one position. The bench sees it at the ACK slot or at the first byte read back. A drive while SCL is high would be seen by the bench as a false start or stop at that same clock phase.

// File: rtl/i2c_append_regs.sv
module i2c_append_regs #(
  parameter logic [6:0] DEV_ADDR   = 7'h36,
  parameter int         BYTE_REGS  = 64,
  parameter int         WIDE_REGS  = 16,
  parameter int         WIDE_BYTES = 16,
  parameter logic [7:0] APPEND_SUB = 8'hFE,
  localparam int        OFF_W      = $clog2(WIDE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [7:0]       wr_addr,
  output logic [OFF_W-1:0] wr_off,
  output logic [7:0]       wr_data,
  output logic [7:0]       rd_addr,
  input  logic [7:0]       rd_data
);
  localparam logic [8:0]     WIDE_LO = 9'(BYTE_REGS);
  localparam logic [8:0]     WIDE_HI = 9'(BYTE_REGS + WIDE_REGS);
  localparam logic [OFF_W:0] OFF_END = (OFF_W+1)'(WIDE_BYTES);

  typedef enum logic [2:0] {IDLE, ADDR, SUB, WDATA, RDATA} st_t;
  typedef enum logic [1:0] {M_BYTE, M_WIDE, M_DROP} mode_t;

  st_t            st;
  mode_t          mode;
  logic [2:0]     scl_q, sda_q;
  logic [3:0]     bitcnt;
  logic [7:0]     shreg, txreg, ptr, wreg;
  logic [OFF_W:0] woff;
  logic           ack_drv, app_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl      = scl_q[1];
  wire sda      = sda_q[1];
  wire scl_rise = scl & ~scl_q[2];
  wire scl_fall = ~scl & scl_q[2];
  wire start_c  = scl & scl_q[2] & ~sda & sda_q[2];
  wire stop_c   = scl & scl_q[2] & sda & ~sda_q[2];

  wire       is_byte  = {1'b0, ptr} < WIDE_LO;
  wire       sub_wide = ({1'b0, shreg} >= WIDE_LO) && ({1'b0, shreg} < WIDE_HI);
  wire [7:0] rd_byte  = is_byte ? rd_data : 8'h00;
  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; mode <= M_DROP; bitcnt <= '0; shreg <= '0; txreg <= '0;
      ptr <= '0; wreg <= '0; woff <= '0; ack_drv <= 1'b0; app_ok <= 1'b0;
      sda_oe <= 1'b0; wr_stb <= 1'b0; wr_addr <= '0; wr_off <= '0; wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        st <= ADDR; bitcnt <= '0; ack_drv <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= IDLE; ack_drv <= 1'b0; sda_oe <= 1'b0;
      end else if (st != IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda};
            bitcnt <= bitcnt + 4'd1;
          end else if (st == RDATA && bitcnt == 4'd8) begin
            if (sda) st <= IDLE;
            else     bitcnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (st == RDATA) begin
            if (bitcnt == 4'd9) begin
              txreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              bitcnt <= '0;
              if (is_byte) ptr <= ptr + 8'd1;
            end else if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
            end else if (bitcnt != 4'd0) begin
              sda_oe <= ~txreg[6];
              txreg  <= {txreg[6:0], 1'b0};
            end
          end else if (ack_drv) begin
            ack_drv <= 1'b0; sda_oe <= 1'b0; bitcnt <= '0;
          end else if (bitcnt == 4'd8) begin
            ack_drv <= 1'b1; sda_oe <= 1'b1;
            case (st)
              ADDR:
                if (shreg[7:1] != DEV_ADDR) begin
                  st <= IDLE; ack_drv <= 1'b0; sda_oe <= 1'b0;
                end else if (shreg[0]) begin
                  st <= RDATA; ack_drv <= 1'b0; bitcnt <= 4'd9;
                end else st <= SUB;
              SUB: begin
                ptr <= shreg;
                st  <= WDATA;
                if (shreg == APPEND_SUB) mode <= app_ok ? M_WIDE : M_DROP;
                else if (sub_wide) begin
                  mode <= M_WIDE; app_ok <= 1'b1; wreg <= shreg; woff <= '0;
                end else begin
                  mode <= M_BYTE; app_ok <= 1'b0;
                end
              end
              WDATA:
                case (mode)
                  M_BYTE:
                    if (is_byte) begin
                      wr_stb <= 1'b1; wr_addr <= ptr; wr_off <= '0; wr_data <= shreg;
                      ptr <= ptr + 8'd1;
                    end
                  M_WIDE:
                    if (woff < OFF_END) begin
                      wr_stb <= 1'b1; wr_addr <= wreg; wr_off <= woff[OFF_W-1:0];
                      wr_data <= shreg; woff <= woff + 1'b1;
                    end
                  default: ;
                endcase
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_append_regs_sva.sv
module i2c_append_regs_sva #(
  parameter int OFF_W     = 4,
  parameter int BYTE_REGS = 64,
  parameter int WIDE_REGS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic             wr_stb,
  input logic [7:0]       wr_addr,
  input logic [OFF_W-1:0] wr_off
);
  localparam logic [8:0] LO = 9'(BYTE_REGS);
  localparam logic [8:0] HI = 9'(BYTE_REGS + WIDE_REGS);

  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_strobe_mapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ({1'b0, wr_addr} < HI));

  p_byte_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ({1'b0, wr_addr} < LO)) |-> (wr_off == '0));

  p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c_append_regs i2c_append_regs_sva #(
  .OFF_W(OFF_W), .BYTE_REGS(BYTE_REGS), .WIDE_REGS(WIDE_REGS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_off(wr_off)
);

// File: tb/i2c_append_regs_bench.sv
module i2c_append_regs_bench;
  localparam int Q = 15;
  localparam logic [6:0] ME = 7'h36;

  logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic       sda_oe, wr_stb;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [3:0] wr_off;
  wire        sda = ~(m_low | sda_oe);

  assign rd_data = rd_addr ^ 8'hA5;
  always #10 clk = ~clk;

  i2c_append_regs u_i2c_append_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_off(wr_off), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, fails = 0, ln = 0, pulse_err = 0, drive_err = 0, nack_cnt = 0;
  logic [7:0] la [0:255];
  logic [3:0] lo [0:255];
  logic [7:0] ld [0:255];
  logic [7:0] buf_ [0:31];
  logic [7:0] rbuf [0:7];
  logic prev_stb = 1'b0, prev_oe = 1'b0, rel_after = 1'b0;
  bit   done = 1'b0;

  always @(negedge clk) begin
    if (wr_stb === 1'b1 && ln < 256) begin
      la[ln] = wr_addr; lo[ln] = wr_off; ld[ln] = wr_data; ln++;
    end
    if (wr_stb === 1'b1 && prev_stb) pulse_err++;
    if (sda_oe === 1'b1 && !prev_oe && scl) drive_err++;
    prev_stb = (wr_stb === 1'b1);
    prev_oe  = (sda_oe === 1'b1);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_low = 1'b0; hold(Q); scl = 1'b1; hold(Q); m_low = 1'b1; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic m_stop();
    m_low = 1'b1; hold(Q); scl = 1'b1; hold(Q); m_low = 1'b0; hold(2*Q);
  endtask

  task automatic m_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
    end
    m_low = 1'b0; hold(Q); scl = 1'b1; hold(Q); ack = ~sda; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic m_recv(input logic give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); scl = 1'b1; hold(Q); b[i] = sda; hold(Q); scl = 1'b0; hold(Q);
    end
    m_low = give_ack; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q); m_low = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] sub, input int n);
    logic ack;
    nack_cnt = 0;
    m_start();
    m_send({a, 1'b0}, ack); if (!ack) nack_cnt++;
    m_send(sub, ack);       if (!ack) nack_cnt++;
    for (int i = 0; i < n; i++) begin
      m_send(buf_[i], ack); if (!ack) nack_cnt++;
    end
    m_stop();
  endtask

  task automatic do_read(input logic set_sub, input logic [7:0] sub, input int n);
    logic ack;
    logic [7:0] b;
    nack_cnt = 0;
    m_start();
    if (set_sub) begin
      m_send({ME, 1'b0}, ack); if (!ack) nack_cnt++;
      m_send(sub, ack);        if (!ack) nack_cnt++;
      m_start();
    end
    m_send({ME, 1'b1}, ack); if (!ack) nack_cnt++;
    for (int i = 0; i < n; i++) begin
      m_recv(i < n - 1, b); rbuf[i] = b;
    end
    hold(4);
    rel_after = sda_oe;
    m_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // sub[31:24] data[23:16] exp_addr[15:8] exp_off[7:4] strobe_expected[0]
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    32'h00_11_00_01, 32'h3F_22_3F_01, 32'hFE_33_00_00, 32'h50_44_00_00,
    32'h42_55_42_01, 32'hFE_66_42_11, 32'hFE_77_42_21, 32'h10_88_10_01,
    32'hFE_99_00_00, 32'h4F_AA_4F_01
  };

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n0;
    hold(5);
    chk("R10 sda_oe in reset", 32'(sda_oe), 0);
    chk("R10 wr_stb in reset", 32'(wr_stb), 0);
    rst_n = 1'b1; hold(5);

    // R7: append before any wide write
    buf_[0] = 8'h5A; buf_[1] = 8'hA5;
    n0 = ln; do_write(ME, 8'hFE, 2);
    chk("R7 no strobe", 32'(ln - n0), 0);
    chk("R7 bytes acked", 32'(nack_cnt), 0);

    // Table: single-byte writes through byte, unmapped, wide and append
    for (int v = 0; v < NV; v++) begin
      buf_[0] = VEC[v][23:16];
      n0 = ln; do_write(ME, VEC[v][31:24], 1);
      chk("R1 R2 R6 acked", 32'(nack_cnt), 0);
      chk("R2 R4 R5 R6 strobe count", 32'(ln - n0), 32'(VEC[v][0]));
      if (VEC[v][0] && ln > n0) begin
        chk("R2 R4 R5 addr", 32'(la[n0]), 32'(VEC[v][15:8]));
        chk("R4 R5 offset",  32'(lo[n0]), 32'(VEC[v][7:4]));
        chk("R2 R4 data",    32'(ld[n0]), 32'(VEC[v][23:16]));
      end
    end

    // R2 multi-byte write running past the byte range
    buf_[0] = 8'h01; buf_[1] = 8'h02; buf_[2] = 8'h03;
    n0 = ln; do_write(ME, 8'h3E, 3);
    chk("R2 boundary count", 32'(ln - n0), 2);
    chk("R2 first addr", 32'(la[n0]), 32'h3E);
    chk("R2 second addr", 32'(la[n0+1]), 32'h3F);
    chk("R2 second data", 32'(ld[n0+1]), 32'h02);

    // R4/R5 chunked wide write with interleaved traffic
    for (int i = 0; i < 4; i++) buf_[i] = 8'hC0 + 8'(i);
    n0 = ln; do_write(ME, 8'h47, 4);
    chk("R4 chunk1 count", 32'(ln - n0), 4);
    chk("R4 chunk1 last off", 32'(lo[n0+3]), 3);
    chk("R4 chunk1 last data", 32'(ld[n0+3]), 32'hC3);

    n0 = ln; do_write(7'h21, 8'h10, 1);
    chk("R1 foreign address nacks", 32'(nack_cnt), 3);
    chk("R1 foreign no strobe", 32'(ln - n0), 0);

    do_read(1'b0, 8'h00, 1);
    chk("R3 current read of wide ptr", 32'(rbuf[0]), 0);

    for (int i = 0; i < 4; i++) buf_[i] = 8'hD0 + 8'(i);
    n0 = ln; do_write(ME, 8'hFE, 4);
    chk("R5 chunk2 count", 32'(ln - n0), 4);
    chk("R5 chunk2 addr", 32'(la[n0]), 32'h47);
    chk("R5 chunk2 first off", 32'(lo[n0]), 4);
    chk("R5 chunk2 first data", 32'(ld[n0]), 32'hD0);
    chk("R5 chunk2 last off", 32'(lo[n0+3]), 7);

    for (int i = 0; i < 12; i++) buf_[i] = 8'hE0 + 8'(i);
    n0 = ln; do_write(ME, 8'hFE, 12);
    chk("R4 overflow count", 32'(ln - n0), 8);
    chk("R4 overflow last off", 32'(lo[n0+7]), 15);
    chk("R4 overflow last data", 32'(ld[n0+7]), 32'hE7);

    n0 = ln; do_write(ME, 8'hFE, 4);
    chk("R4 full register no strobe", 32'(ln - n0), 0);

    // R3 reads
    do_read(1'b1, 8'h3E, 3);
    chk("R3 addr/sub acked", 32'(nack_cnt), 0);
    chk("R3 byte0", 32'(rbuf[0]), 32'h9B);
    chk("R3 byte1", 32'(rbuf[1]), 32'h9A);
    chk("R3 byte2 past range", 32'(rbuf[2]), 32'h00);
    chk("R3 released after nack", 32'(rel_after), 0);

    do_read(1'b1, 8'hFE, 1);
    chk("R3 read at append sub", 32'(rbuf[0]), 32'h00);

    // R10: reset cancels a pending append
    buf_[0] = 8'h31;
    do_write(ME, 8'h44, 1);
    rst_n = 1'b0; hold(3); rst_n = 1'b1; hold(3);
    n0 = ln; do_write(ME, 8'hFE, 1);
    chk("R10 append cleared by reset", 32'(ln - n0), 0);

    chk("R9 strobe single cycle", 32'(pulse_err), 0);
    chk("R8 drive only while SCL low", 32'(drive_err), 0);
    finish_run();
  end
endmodule